// File: doc/BRIEF.md
# Error Header Log Queue

This block keeps the uncorrectable-error logging state of an advanced error reporting function on a PCI Express style link. It owns the uncorrectable status register, which software clears by writing ones. It also owns the first-error pointer, the four-dword header log and the four-dword prefix log. Error records arrive on a one-cycle strobe. Each record carries a one-hot status vector, a header-valid flag with four header dwords, and a prefix-present flag with four prefix dwords.

When multiple-header recording is enabled and the error named by the first-error pointer is still pending, new records wait in a small queue. They do not overwrite the log. When software clears the pending first error, the oldest queued record moves into the log. The status bits of the records still waiting are set again, so a clear cannot hide them. A record that finds the queue full raises a one-cycle overflow pulse. Severity and message routing are handled elsewhere.

Top module: `aer_hdr_log`

## Requirements
- R1: After reset the status register, the first-error pointer, both logs, the prefix-logged bit, the enable bit and the queue are all zero, and the overflow output is low.
- R2: A record whose status has exactly one bit set sets that bit in the status register. A record that is not queued loads the index of that bit into the first-error pointer (cap_ctl[4:0]). A record with zero or several status bits has no effect.
- R3: On a log load with header-valid set, header dword k (rec_hdr[32k+31:32k]) is written to hdr_log[32k+31:32k] with its four bytes reversed. With header-valid clear, the header log becomes zero.
- R4: On a log load, the prefix dwords are stored byte-reversed in the same layout and the prefix-logged bit cap_ctl[7] is set, but only when both rec_pfx_present and e2e_pfx_en are high. Otherwise the prefix log becomes zero and cap_ctl[7] is cleared.
- R5: When the enable bit cap_ctl[6] is set and the status bit at the first-error pointer is set, a new record is queued. The pointer and the logs stay unchanged.
- R6: A record that should be queued while the queue holds DEPTH entries is dropped. log_overflow is high for the one cycle after it, and the record's status bit is still set.
- R7: A status write clears every status bit written as 1. If the first error's bit stays set and queuing is enabled, the status bits of all queued records are set again.
- R8: If a status write clears the first error's bit while queuing is enabled and the queue is not empty, the status bits of all queued records are set again. The oldest record is then removed from the queue and loaded into the log.
- R9: If a status write clears the first error's bit while queuing is disabled or the queue is empty, the first-error pointer, cap_ctl[7] and both logs become zero.
- R10: A control write sets the enable bit from ctl_wdata[6] and always empties the queue. cap_ctl[5] reads 1 when DEPTH > 0. Bits 15:8 of cap_ctl read 0.
- R11: With DEPTH = 0, cap_ctl[5] and cap_ctl[6] always read 0, whatever is written.
- R12: Only one operation is taken per cycle, in the priority control write, then status write, then record. A lower-priority operation in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e2e_pfx_en | input | 1 | End-to-end prefix support is configured |
| rec_valid | input | 1 | Record strobe |
| rec_status | input | 32 | One-hot uncorrectable status of the record |
| rec_hdr_valid | input | 1 | Header dwords are valid |
| rec_hdr | input | 128 | Four header dwords, dword k at [32k+31:32k] |
| rec_pfx_present | input | 1 | Prefix dwords are present |
| rec_pfx | input | 128 | Four prefix dwords, same layout |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Write-1-to-clear data |
| ctl_wr | input | 1 | Capability/control write strobe |
| ctl_wdata | input | 16 | Control data; bit 6 is the enable |
| unc_status | output | 32 | Uncorrectable status register |
| cap_ctl | output | 16 | [4:0] first-error pointer, [5] capable, [6] enable, [7] prefix logged |
| hdr_log | output | 128 | Header log |
| pfx_log | output | 128 | Prefix log |
| log_overflow | output | 1 | One-cycle pulse when a record is lost to a full queue |

## Verification
The bench targets the status write that leaves the first error pending while other records wait. A design that skips the re-set would lose the queued bits from the status register. It also targets the clear that pops the queue. A wrong design there would load the newest record, or would drop the popped record's own status bit. The bench fills the queue exactly to DEPTH and sends one more record. A design off by one would either miss the overflow pulse or lose a record early. It also checks the control write that flushes the queue, after which a clear must empty the log instead of popping a stale record. Prefix logging is tried with each of its two enables off, and records with no bits or two bits set are sent to confirm they leave no trace.

// File: rtl/aer_hdr_log.sv
module aer_hdr_log #(
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         e2e_pfx_en,
  input  logic         rec_valid,
  input  logic [31:0]  rec_status,
  input  logic         rec_hdr_valid,
  input  logic [127:0] rec_hdr,
  input  logic         rec_pfx_present,
  input  logic [127:0] rec_pfx,
  input  logic         sts_wr,
  input  logic [31:0]  sts_wdata,
  input  logic         ctl_wr,
  input  logic [15:0]  ctl_wdata,
  output logic [31:0]  unc_status,
  output logic [15:0]  cap_ctl,
  output logic [127:0] hdr_log,
  output logic [127:0] pfx_log,
  output logic         log_overflow
);
  localparam int QD = (DEPTH > 0) ? DEPTH : 1;
  localparam int CW = $clog2(QD + 1);
  localparam logic HAS_MH = (DEPTH > 0);

  typedef struct packed {
    logic [4:0]   idx;
    logic         hv;
    logic [127:0] hdr;
    logic         pp;
    logic [127:0] pfx;
  } rec_t;

  function automatic logic [127:0] be4(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 4; b++)
        r[32*k + 8*b +: 8] = d[32*k + 8*(3-b) +: 8];
    return r;
  endfunction

  rec_t           q [QD];
  logic [CW-1:0]  cnt;
  logic [4:0]     fep, in_idx;
  logic           mh_en, pfx_flag;
  logic [31:0]    qor;
  rec_t           inc, ld;

  always_comb begin
    in_idx = '0;
    for (int i = 0; i < 32; i++)
      if (rec_status[i]) in_idx = 5'(i);
  end

  always_comb begin
    qor = '0;
    for (int i = 0; i < QD; i++)
      if (i < int'(cnt)) qor[q[i].idx] = 1'b1;
  end

  wire do_ctl = ctl_wr;
  wire do_sts = sts_wr && !ctl_wr;
  wire do_rec = rec_valid && $onehot(rec_status) && !ctl_wr && !sts_wr;

  wire        q_full    = (int'(cnt) == QD);
  wire        to_queue  = do_rec && mh_en && unc_status[fep];
  wire [31:0] sts_after = unc_status & ~sts_wdata;
  wire        first_clr = !sts_after[fep];
  wire        pop       = do_sts && first_clr && mh_en && (cnt != '0);
  wire        clr_log   = do_sts && first_clr && !pop;
  wire        load      = (do_rec && !to_queue) || pop;

  assign inc = '{idx: in_idx, hv: rec_hdr_valid, hdr: rec_hdr,
                 pp: rec_pfx_present, pfx: rec_pfx};
  assign ld  = pop ? q[0] : inc;

  logic unused_ctl;
  assign unused_ctl = ^{ctl_wdata[15:7], ctl_wdata[5:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unc_status   <= '0;
      fep          <= '0;
      mh_en        <= 1'b0;
      pfx_flag     <= 1'b0;
      hdr_log      <= '0;
      pfx_log      <= '0;
      log_overflow <= 1'b0;
      cnt          <= '0;
      for (int i = 0; i < QD; i++) q[i] <= '0;
    end else begin
      log_overflow <= to_queue && q_full;
      if (do_ctl) begin
        mh_en <= ctl_wdata[6] & HAS_MH;
        cnt   <= '0;
      end else if (do_sts) begin
        unc_status <= sts_after | (mh_en ? qor : 32'h0);
        if (pop) begin
          for (int i = 0; i < QD - 1; i++) q[i] <= q[i+1];
          cnt <= cnt - 1'b1;
        end
      end else if (do_rec) begin
        unc_status <= unc_status | rec_status;
        if (to_queue && !q_full) begin
          q[cnt] <= inc;
          cnt    <= cnt + 1'b1;
        end
      end
      if (load) begin
        fep     <= ld.idx;
        hdr_log <= ld.hv ? be4(ld.hdr) : '0;
        if (ld.pp && e2e_pfx_en) begin
          pfx_log  <= be4(ld.pfx);
          pfx_flag <= 1'b1;
        end else begin
          pfx_log  <= '0;
          pfx_flag <= 1'b0;
        end
      end else if (clr_log) begin
        fep      <= '0;
        hdr_log  <= '0;
        pfx_log  <= '0;
        pfx_flag <= 1'b0;
      end
    end
  end

  assign cap_ctl = {8'h00, pfx_flag, mh_en, HAS_MH, fep};

  // R6
  ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_overflow |-> (int'($past(cnt)) == QD));

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= QD);

  // R10
  ctl_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (cnt == '0));

  // R11
  queue_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mh_en |-> (cnt == '0));

  // R2
  pointer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rec && !mh_en) |=> (fep == $past(in_idx)));

  // R7
  pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_sts && mh_en && !first_clr) |=> $stable(fep));
endmodule

// File: tb/aer_hdr_log_test.sv
module aer_hdr_log_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic e2e_pfx_en = 1'b0, rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_pfx_present = 1'b0;
  logic [31:0] rec_status = '0, sts_wdata = '0;
  logic [127:0] rec_hdr = '0, rec_pfx = '0;
  logic sts_wr = 1'b0, ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [31:0] unc_status, unc0;
  logic [15:0] cap_ctl, cap0;
  logic [127:0] hdr_log, pfx_log, hl0, pl0;
  logic log_overflow, ovf0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  aer_hdr_log uut (.clk, .rst_n, .e2e_pfx_en, .rec_valid, .rec_status, .rec_hdr_valid,
    .rec_hdr, .rec_pfx_present, .rec_pfx, .sts_wr, .sts_wdata, .ctl_wr, .ctl_wdata,
    .unc_status, .cap_ctl, .hdr_log, .pfx_log, .log_overflow);

  aer_hdr_log #(.DEPTH(0)) uut_nomh (.clk, .rst_n, .e2e_pfx_en, .rec_valid, .rec_status,
    .rec_hdr_valid, .rec_hdr, .rec_pfx_present, .rec_pfx, .sts_wr, .sts_wdata, .ctl_wr,
    .ctl_wdata, .unc_status(unc0), .cap_ctl(cap0), .hdr_log(hl0), .pfx_log(pl0),
    .log_overflow(ovf0));

  // idx[7:3], header valid [2], prefix present [1], prefix support [0]
  localparam logic [7:0] VEC [6] = '{
    {5'd3, 3'b111}, {5'd0, 3'b101}, {5'd31, 3'b011},
    {5'd17, 3'b110}, {5'd8, 3'b000}, {5'd25, 3'b111}};

  function automatic logic [127:0] swap(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 4; k++)
      r[32*k +: 32] = {d[32*k +: 8], d[32*k+8 +: 8], d[32*k+16 +: 8], d[32*k+24 +: 8]};
    return r;
  endfunction

  function automatic logic [127:0] mk_hdr(input int idx);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) r[32*k +: 32] = {8'(idx), 8'(k), 16'hA5C3};
    return r;
  endfunction

  function automatic logic [127:0] mk_pfx(input int idx);
    return ~mk_hdr(idx) ^ 128'h5;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic record(input logic [31:0] st, input int idx, input logic hv, input logic pp);
    @(negedge clk);
    rec_valid = 1'b1; rec_status = st; rec_hdr_valid = hv; rec_pfx_present = pp;
    rec_hdr = mk_hdr(idx); rec_pfx = mk_pfx(idx);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic sts_write(input logic [31:0] d);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = d;
    @(negedge clk); sts_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic [15:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", 128'(unc_status), 0);
    check("R1 cap", 128'(cap_ctl), 128'h20);
    check("R1 hdr", hdr_log, 0);
    check("R1 ovf", 128'(log_overflow), 0);

    // R2 R3 R4 table walk with queuing disabled
    acc = '0;
    for (int v = 0; v < 6; v++) begin
      int idx;
      logic hv, pp, sup;
      idx = int'(VEC[v][7:3]); hv = VEC[v][2]; pp = VEC[v][1]; sup = VEC[v][0];
      e2e_pfx_en = sup;
      record(32'h1 << idx, idx, hv, pp);
      acc |= 32'h1 << idx;
      check("R2 pointer", 128'(cap_ctl[4:0]), 128'(idx));
      check("R2 status", 128'(unc_status), 128'(acc));
      check("R3 header", hdr_log, hv ? swap(mk_hdr(idx)) : 128'h0);
      check("R4 prefix", pfx_log, (pp && sup) ? swap(mk_pfx(idx)) : 128'h0);
      check("R4 flag", 128'(cap_ctl[7]), 128'(pp && sup));
    end

    // R9 clear with queuing off
    sts_write(32'hFFFF_FFFF);
    check("R9 status", 128'(unc_status), 0);
    check("R9 cap", 128'(cap_ctl), 128'h20);
    check("R9 logs", hdr_log | pfx_log, 0);

    // R10 enable
    e2e_pfx_en = 1'b1;
    ctl_write(16'h0040);
    check("R10 cap", 128'(cap_ctl), 128'h60);
    check("R11 no-depth cap", 128'(cap0[6:5]), 0);

    // R5 queuing
    record(32'h1 << 4, 4, 1'b1, 1'b0);
    record(32'h1 << 12, 12, 1'b1, 1'b1);
    record(32'h1 << 20, 20, 1'b0, 1'b1);
    check("R5 status", 128'(unc_status), 128'(32'h0010_1010));
    check("R5 pointer", 128'(cap_ctl[4:0]), 4);
    check("R5 header kept", hdr_log, swap(mk_hdr(4)));

    // R7 clear a queued bit while the first error stays pending
    sts_write(32'h0000_1000);
    check("R7 reassert", 128'(unc_status), 128'(32'h0010_1010));
    check("R7 pointer", 128'(cap_ctl[4:0]), 4);

    // R8 clear the first error: oldest queued record loads
    sts_write(32'h0010_1010);
    check("R8 status", 128'(unc_status), 128'(32'h0010_1000));
    check("R8 pointer", 128'(cap_ctl[4:0]), 12);
    check("R8 header", hdr_log, swap(mk_hdr(12)));
    check("R8 prefix", pfx_log, swap(mk_pfx(12)));
    check("R8 flag", 128'(cap_ctl[7]), 1);

    // R6 fill to depth, then overflow
    for (int i = 1; i <= 7; i++) begin
      record(32'h1 << i, i, 1'b1, 1'b0);
      check("R6 no early overflow", 128'(log_overflow), 0);
    end
    record(32'h1 << 9, 9, 1'b1, 1'b0);
    check("R6 overflow pulse", 128'(log_overflow), 1);
    @(negedge clk);
    check("R6 pulse ends", 128'(log_overflow), 0);
    check("R6 status", 128'(unc_status), 128'(32'h0010_12FE));

    // R10 flush, then R9 clear with empty queue
    ctl_write(16'h0040);
    sts_write(32'h0000_1000);
    check("R9 after flush status", 128'(unc_status), 128'(32'h0010_02FE));
    check("R9 after flush pointer", 128'(cap_ctl), 128'h60);
    check("R9 after flush header", hdr_log, 0);

    // R12 priority
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 16'h0040; rec_valid = 1'b1; rec_status = 32'h4000_0000;
    @(negedge clk);
    ctl_wr = 1'b0; rec_valid = 1'b0;
    check("R12 ctl over rec", 128'(unc_status[30]), 0);
    @(negedge clk);
    sts_wr = 1'b1; sts_wdata = 32'h0010_0000; rec_valid = 1'b1; rec_status = 32'h2000_0000;
    @(negedge clk);
    sts_wr = 1'b0; rec_valid = 1'b0;
    check("R12 sts over rec", 128'(unc_status), 128'(32'h0000_02FE));

    // R2 non-one-hot ignored
    record(32'h0000_0C00, 10, 1'b1, 1'b1);
    check("R2 multi-bit ignored", 128'(unc_status), 128'(32'h0000_02FE));
    record(32'h0, 10, 1'b1, 1'b1);
    check("R2 zero ignored", 128'(cap_ctl), 128'h60);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", 128'(unc_status), 0);
    check("R1 reset cap", 128'(cap_ctl), 128'h20);
    check("R1 reset logs", hdr_log | pfx_log, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule